// File: doc/BRIEF.md
# Serial sensor register writer

This block lets on-chip logic program the internal registers of an image sensor over a three-wire serial link: a serial clock, a serial data line and a commit (enable) line. The requester presents a 4-bit register address and a 12-bit value together with a one-cycle request. The block joins them into a 16-bit word, with the address in the upper four bits and the value in the lower twelve. It shifts the word out most significant bit first on a serial clock divided down from the system clock, then raises the commit line for one serial period so that the sensor copies its shift buffer into the addressed register.

The divider sets the half period of the serial clock. The divider value is captured when a request is accepted, so a slow sensor limit, such as a few MHz at most, can be met from any system clock. The block takes a request only while it is idle. It holds `busy` for the whole transfer and gives a one-cycle `done` pulse when the commit line drops.

Top module: `sreg_writer`

## Requirements
- R1: The serial word is {req_addr, req_data}: bits 15..12 carry the address and bits 11..0 carry the data. It is sent most significant bit first, so the bit sampled at the k-th rising edge of ser_clk (k = 0..15) is word bit 15-k.
- R2: ser_data changes only while ser_clk is low, that is at acceptance or when ser_clk falls. It stays constant for as long as ser_clk is high.
- R3: ser_clk is low when idle. Each transfer has exactly 16 rising edges. Every high phase and every low phase of ser_clk lasts div_half+1 system clock cycles, using the div_half value captured at acceptance. Changes to div_half during a transfer have no effect on it.
- R4: ser_en stays low while bits are shifted. It rises with the 16th falling edge of ser_clk and stays high for 2*(div_half+1) cycles. ser_clk stays low while ser_en is high.
- R5: A request is accepted only when busy is low. A request made while busy is ignored: it neither changes the word in flight nor starts a later transfer.
- R6: busy rises in the cycle after the accepting clock edge. It stays high for exactly 34*(div_half+1) cycles and falls in the same cycle as ser_en.
- R7: done is a single-cycle pulse. It is high in exactly the cycle in which ser_en has just fallen, and at no other time.
- R8: During and right after reset, busy, done, ser_clk, ser_en and ser_data are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request, taken when idle |
| req_addr | input | 4 | Target register address |
| req_data | input | 12 | Register value |
| div_half | input | 8 | Serial half period, minus one, in system cycles |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at end of commit |
| ser_clk | output | 1 | Serial clock to sensor |
| ser_data | output | 1 | Serial data to sensor |
| ser_en | output | 1 | Commit strobe to sensor |

## Verification
The bench rebuilds each word from the line levels seen at rising serial clock edges. A packing mistake or a reversed bit order shows up as a wrong word, and an off-by-one in the bit index shows up as a shifted one. It goes after divider extremes (0 and the maximum) and changes div_half in mid-transfer. A divider that is not captured at acceptance gives high phases and busy windows of the wrong length. It also fires fresh requests while a transfer is in flight. A design without an idle guard would then corrupt the word or start a stray transfer after the commit. The commit pulse length, the absence of clock edges during commit, and done landing on the exact ser_en fall are each measured. A design that commits early, too long, or reports done one cycle off fails one of these checks.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SHIFT  = 2'd1,
    PH_COMMIT = 2'd2
  } phase_e;

  // serial half periods spent with the commit line high
  localparam int unsigned COMMIT_HALVES = 2;

  // half periods in one whole transfer: two per bit plus the commit
  function automatic int unsigned total_halves(int unsigned word_w);
    return 2 * word_w + COMMIT_HALVES;
  endfunction

  // system cycles in one serial half period for a divider setting
  function automatic int unsigned half_cycles(int unsigned div);
    return div + 1;
  endfunction

endpackage

// File: rtl/sreg_half_timer.sv
module sreg_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             half_end
);

  logic [DIV_W-1:0] cnt_q;

  assign half_end = run && (cnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (restart || half_end)
      cnt_q <= '0;
    else if (run)
      cnt_q <= cnt_q + 1'b1;
  end

  // R3: the counter never passes the captured limit
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= div));

endmodule

// File: rtl/sreg_sequencer.sv
module sreg_sequencer
  import sreg_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int HIDX_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              half_end,
  output logic              busy,
  output logic              done,
  output logic [HIDX_W-1:0] half_idx,
  output phase_e            phase
);

  localparam int unsigned TOTAL = total_halves(WORD_W);
  localparam logic [HIDX_W-1:0] LAST      = HIDX_W'(TOTAL - 1);
  localparam logic [HIDX_W-1:0] SHIFT_END = HIDX_W'(2 * WORD_W);

  logic              busy_q, done_q;
  logic [HIDX_W-1:0] h_q;
  logic              last_half;

  assign last_half = busy_q && half_end && (h_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      h_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        h_q    <= '0;
      end else if (last_half) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        h_q    <= '0;
      end else if (busy_q && half_end) begin
        h_q <= h_q + 1'b1;
      end
    end
  end

  always_comb begin
    if (!busy_q)
      phase = PH_IDLE;
    else if (h_q < SHIFT_END)
      phase = PH_SHIFT;
    else
      phase = PH_COMMIT;
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign half_idx = h_q;

  // R7: done follows the cycle in which the transfer ended
  a_r7_done_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

  // R6: the half index stays within one transfer
  a_r6_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (half_idx <= LAST));

endmodule

// File: rtl/sreg_shifter.sv
module sreg_shifter
  import sreg_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int HIDX_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  input  logic [HIDX_W-1:0] half_idx,
  input  phase_e            phase,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              ser_en
);

  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] aligned;

  // bit to present during a half: word shifted left by the bit number
  function automatic logic [WORD_W-1:0] align_bit(
    input logic [WORD_W-1:0] w, input logic [HIDX_W-1:0] h);
    return w << h[HIDX_W-1:1];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      word_q <= '0;
    else if (load)
      word_q <= word_in;
  end

  assign aligned  = align_bit(word_q, half_idx);
  assign ser_data = (phase == PH_SHIFT) && aligned[WORD_W-1];
  assign ser_clk  = (phase == PH_SHIFT) && half_idx[0];
  assign ser_en   = (phase == PH_COMMIT);

  // R5: the word in flight is frozen until the transfer is over
  a_r5_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase != PH_IDLE) && $past(phase != PH_IDLE)) |-> $stable(word_q));

  // R4: no serial clock edge while committing
  a_r4_no_clk_in_commit: assert property (@(posedge clk) disable iff (!rst_n)
    ser_en |-> !ser_clk);

  // R2: data holds while the serial clock stays high
  a_r2_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

endmodule

// File: rtl/sreg_writer.sv
module sreg_writer
  import sreg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 12,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [DIV_W-1:0]  div_half,
  output logic              busy,
  output logic              done,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              ser_en
);

  localparam int WORD_W = ADDR_W + DATA_W;
  localparam int HIDX_W = $clog2(total_halves(WORD_W));

  logic              accept;
  logic              half_end;
  logic [DIV_W-1:0]  div_q;
  logic [HIDX_W-1:0] half_idx;
  phase_e            phase;

  assign accept = req_valid && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      div_q <= '0;
    else if (accept)
      div_q <= div_half;
  end

  sreg_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (accept),
    .run      (busy),
    .div      (div_q),
    .half_end (half_end)
  );

  sreg_sequencer #(.WORD_W(WORD_W), .HIDX_W(HIDX_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .half_end (half_end),
    .busy     (busy),
    .done     (done),
    .half_idx (half_idx),
    .phase    (phase)
  );

  sreg_shifter #(.WORD_W(WORD_W), .HIDX_W(HIDX_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .word_in  ({req_addr, req_data}),
    .half_idx (half_idx),
    .phase    (phase),
    .ser_clk  (ser_clk),
    .ser_data (ser_data),
    .ser_en   (ser_en)
  );

  // R8: idle link is quiet
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_clk && !ser_en && !ser_data));

  // R6: commit only inside the busy window
  a_r6_en_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ser_en |-> busy);

  // R7: done coincides with the fall of the commit line
  a_r7_done_on_en_fall: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(ser_en) && !ser_en));

  // R6: a request taken while idle raises busy on the next cycle
  a_r6_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);

endmodule

// File: tb/sim_sreg_writer.sv
module sim_sreg_writer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [11:0] req_data = '0;
  logic [7:0]  div_half = '0;
  logic        busy, done, ser_clk, ser_data, ser_en;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  sreg_writer u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .div_half(div_half), .busy(busy), .done(done),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_en(ser_en)
  );

  function automatic logic [15:0] exp_word(logic [3:0] a, logic [11:0] d);
    return {a, d};
  endfunction

  function automatic int exp_busy(int div);
    return 34 * (div + 1);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run_xfer(logic [3:0] a, logic [11:0] d, int div, bit inject);
    logic [15:0] cap = '0;
    int rises = 0, hi_len = 0, hi_bad = 0, r2_bad = 0, r4_bad = 0;
    int sen_len = 0, busy_cnt = 0, done_cnt = 0, r7_bad = 0, idle_bad = 0;
    bit prev_clk = 0, prev_sen = 0, prev_dat = 0, fin = 0;
    int it = 0;
    @(negedge clk);
    req_addr = a; req_data = d; div_half = 8'(div); req_valid = 1'b1;
    while (!fin && it < 20000) begin
      @(negedge clk);
      if (it == 0) begin
        req_valid = 1'b0;
        check(busy == 1'b1, "R6 busy after accept", busy, 1);
      end
      if (inject && it == 5) begin
        req_addr = ~a; req_data = ~d; req_valid = 1'b1;
        div_half = 8'($urandom_range(0, 9));
      end
      if (inject && it == 6) req_valid = 1'b0;
      if (busy) busy_cnt++;
      if (ser_clk && !prev_clk) begin
        rises++;
        cap = {cap[14:0], ser_data};
      end
      if (ser_clk) hi_len++;
      else if (prev_clk) begin
        if (hi_len != div + 1) hi_bad++;
        hi_len = 0;
      end
      if (ser_clk && prev_clk && ser_data != prev_dat) r2_bad++;
      if (ser_en) begin
        sen_len++;
        if (ser_clk || rises != 16) r4_bad++;
      end
      if (done) begin
        done_cnt++;
        if (!(prev_sen && !ser_en && !busy)) r7_bad++;
        fin = 1;
      end
      prev_clk = ser_clk; prev_sen = ser_en; prev_dat = ser_data;
      it++;
    end
    check(cap == exp_word(a, d), "R1 word", int'(cap), int'(exp_word(a, d)));
    check(rises == 16, "R3 edges", rises, 16);
    check(hi_bad == 0, "R3 high width", hi_bad, 0);
    check(r2_bad == 0, "R2 data stable", r2_bad, 0);
    check(sen_len == 2 * (div + 1), "R4 commit len", sen_len, 2 * (div + 1));
    check(r4_bad == 0, "R4 commit clean", r4_bad, 0);
    check(busy_cnt == exp_busy(div), "R6 busy len", busy_cnt, exp_busy(div));
    check(done_cnt == 1 && r7_bad == 0, "R7 done at en fall", done_cnt, 1);
    @(negedge clk);
    check(done == 1'b0, "R7 done width", done, 0);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (busy || ser_clk || ser_en || ser_data) idle_bad++;
    end
    check(idle_bad == 0, "R5 no stray transfer", idle_bad, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    check({busy, done, ser_clk, ser_en, ser_data} == 5'b0, "R8 in reset",
          int'({busy, done, ser_clk, ser_en, ser_data}), 0);
    req_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check({busy, done, ser_clk, ser_en, ser_data} == 5'b0, "R8 after reset",
          int'({busy, done, ser_clk, ser_en, ser_data}), 0);
    run_xfer(4'hF, 12'h000, 0, 1'b0);
    run_xfer(4'h0, 12'hFFF, 0, 1'b0);
    run_xfer(4'hA, 12'h5A5, 255, 1'b0);
    run_xfer(4'h1, 12'h801, 3, 1'b1);
    run_xfer(4'h8, 12'h001, 0, 1'b1);
    for (int n = 0; n < 14; n++) begin
      run_xfer(4'($urandom), 12'($urandom), int'($urandom_range(0, 6)),
               1'(n % 2));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule